// File: doc/BRIEF.md
# Three-Timer Interrupt Status Block

This block holds three down-counting timers together with their control and interrupt logic. It is reached through a simple word-addressed register bus. Each timer has its own clock-source choice, a count enable, an interrupt enable and a programmable reload value. When an enabled timer reaches zero, it reloads itself. If its interrupt enable is set, it also latches a sticky status bit. The three status bits are ORed onto one interrupt request line.

Software reads the control/status word to see which timers are pending, because more than one can be pending at once. It can retire one source in either of two ways. The first is to write 0 to that source's bit in the control/status word. The second is to write any value to that timer's own clear address, which touches no other control bit.

Top module: `multi_timer_irq`

## Requirements
- R1: After reset, every readable register reads 0 and `irq` is low.
- R2: Address 0 is the control/status word. For timer i, bit 4i is the count enable, bit 4i+1 is the interrupt enable, and bits 4i+3:4i+2 are the clock select. Bit 16+i is the sticky status bit. All of these fields read back as written.
- R3: A timer whose count enable is 0 holds its count value unchanged.
- R4: Writing address 4+i sets the reload value of timer i and loads that value into its counter. Address 12+i reads the live count. An enabled timer decrements once per tick. On the tick where the count is 0, it reloads instead, so the expiry period is (reload+1) ticks.
- R5: Clock select 0 ticks every cycle. Select 1 ticks every 2nd cycle, and select 2 ticks every 4th cycle, both taken from a free-running prescaler. Select 3 ticks once per rising edge of `ext_tick`, after that input passes through a two-stage synchronizer.
- R6: An expiry sets the timer's status bit only when its interrupt enable is 1. Otherwise the status bit stays 0.
- R7: `irq` is high while any status bit is 1, and it stays high until the last one is cleared.
- R8: A write to address 0 with a 0 in bit 16+i clears status i. A 1 in that bit leaves status i unchanged.
- R9: A write of any data to address 8+i clears status i only. All control fields and the other status bits are left as they were.
- R10: If an expiry and a clear of the same status bit happen in the same cycle, the status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_tick | input | 1 | Asynchronous external tick source |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Shared interrupt request |

## Verification
Two situations are hard to reach from the ports. The hardest is a clear that lands in the very cycle a timer expires. The bench gets there by loading a known reload value with the system-clock select, and it counts edges from the enabling write so that the clear-register write falls exactly on the expiry edge. The divided and external selects start at an unknown prescaler or input phase. For those, the bench measures the distance between two consecutive expiries rather than the time of the first one. It does this by clearing the status right after it is seen and timing the next rise of `irq`.

// File: rtl/multi_timer_irq.sv
module multi_timer_irq #(
  parameter int NT = 3,
  parameter int CW = 16,
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_tick,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int STS_LSB  = 16;
  localparam int RLD_BASE = 4;
  localparam int CLR_BASE = 8;
  localparam int CNT_BASE = 12;

  logic [NT-1:0] en, ien, sts, tick, expire, clr, rld_wr;
  logic [1:0]    sel [NT];
  logic [CW-1:0] rld [NT];
  logic [CW-1:0] cnt [NT];
  logic [1:0]    presc;
  logic [2:0]    ext_s;
  logic          ext_rise;

  wire ctrl_wr = bus_wr && (bus_addr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc <= '0;
      ext_s <= '0;
    end else begin
      presc <= presc + 2'd1;
      ext_s <= {ext_s[1:0], ext_tick};
    end
  end
  assign ext_rise = ext_s[1] & ~ext_s[2];

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    always_comb begin
      case (sel[i])
        2'd0:    tick[i] = 1'b1;
        2'd1:    tick[i] = presc[0];
        2'd2:    tick[i] = &presc;
        default: tick[i] = ext_rise;
      endcase
    end

    assign expire[i] = en[i] & tick[i] & (cnt[i] == '0);
    assign rld_wr[i] = bus_wr && (bus_addr == AW'(RLD_BASE + i));
    assign clr[i]    = (ctrl_wr && !bus_wdata[STS_LSB + i]) ||
                       (bus_wr && (bus_addr == AW'(CLR_BASE + i)));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en[i]  <= 1'b0;
        ien[i] <= 1'b0;
        sel[i] <= '0;
        rld[i] <= '0;
        cnt[i] <= '0;
        sts[i] <= 1'b0;
      end else begin
        if (ctrl_wr) begin
          en[i]  <= bus_wdata[4*i];
          ien[i] <= bus_wdata[4*i+1];
          sel[i] <= bus_wdata[4*i+2 +: 2];
        end
        if (rld_wr[i]) begin
          rld[i] <= bus_wdata[CW-1:0];
          cnt[i] <= bus_wdata[CW-1:0];
        end else if (expire[i]) begin
          cnt[i] <= rld[i];
        end else if (en[i] && tick[i]) begin
          cnt[i] <= cnt[i] - 1'b1;
        end
        if (expire[i] && ien[i]) sts[i] <= 1'b1;
        else if (clr[i])         sts[i] <= 1'b0;
      end
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[i] && !rld_wr[i]) |=> $stable(cnt[i]));
    p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[i] <= rld[i]);
    p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[i]) |-> $past(expire[i] && ien[i]));
    p_keep_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && bus_wdata[STS_LSB + i] && sts[i]) |=> sts[i]);
    p_fall_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts[i]) |-> $past(bus_wr && (bus_addr == '0 || bus_addr == AW'(CLR_BASE + i))));
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[i] && ien[i] && clr[i]) |=> sts[i]);
  end

  assign irq = |sts;

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_wr));

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NT; i++) begin
      if (bus_addr == '0) begin
        bus_rdata[4*i]         = en[i];
        bus_rdata[4*i+1]       = ien[i];
        bus_rdata[4*i+2 +: 2]  = sel[i];
        bus_rdata[STS_LSB + i] = sts[i];
      end
      if (bus_addr == AW'(RLD_BASE + i)) bus_rdata[CW-1:0] = rld[i];
      if (bus_addr == AW'(CNT_BASE + i)) bus_rdata[CW-1:0] = cnt[i];
    end
  end
endmodule

// File: tb/sim_multi_timer_irq.sv
`timescale 1ns/1ps
module sim_multi_timer_irq;
  logic clk = 0, rst_n = 0, ext_tick = 0, bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq;
  int n_run = 0, n_fail = 0, ecount = 0;
  logic ext_run = 0;
  logic [1:0] ext_ph = 0;

  multi_timer_irq u0 (.clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #4 clk = ~clk;
  always @(posedge clk) ecount <= ecount + 1;
  always @(negedge clk) if (ext_run) begin ext_ph <= ext_ph + 1; ext_tick <= ext_ph[1]; end
                        else ext_tick <= 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    bus_addr = 4'(a); bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    bus_addr = 4'(a); #1; d = bus_rdata;
  endtask

  task automatic measure(int i, output int per);
    int t1, t2;
    t1 = -1; t2 = -1;
    for (int k = 0; k < 400 && t1 < 0; k++) begin
      @(negedge clk); if (irq) t1 = ecount;
    end
    wr(8 + i, 32'hDEAD);
    for (int k = 0; k < 400 && t2 < 0; k++) begin
      if (irq) t2 = ecount; else @(negedge clk);
    end
    per = t2 - t1;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int per;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    foreach (v[k]) if (k < 15) begin rd(k, v); chk("R1", v, 0); end
    chk("R1 irq", irq, 0);

    // R4/R2: expiry timing with system clock, reload 0..4
    for (int n = 0; n <= 4; n++) begin
      wr(0, 0); wr(4, n);
      rd(12, v); chk("R4 load", v, n);
      wr(0, 32'h3);
      repeat (n) @(negedge clk);
      chk("R4 early", irq, 0);
      @(negedge clk);
      chk("R4 expiry", irq, 1);
      rd(0, v); chk("R2 readback", v, 32'h10003);
    end

    // R3 hold while disabled, R4 decrement, R6 gating
    wr(0, 0); wr(4, 5);
    repeat (10) @(negedge clk);
    rd(12, v); chk("R3 hold", v, 5);
    wr(0, 32'h1);
    repeat (3) @(negedge clk);
    rd(12, v); chk("R4 count", v, 2);
    repeat (20) @(negedge clk);
    chk("R6 irq", irq, 0);
    rd(0, v); chk("R6 status", v, 32'h1);

    // R5 divided and external selects on every timer
    for (int i = 0; i < 3; i++)
      for (int s = 1; s <= 3; s++)
        for (int n = 1; n <= 3; n++) begin
          wr(0, 0); wr(4 + i, n);
          ext_run = (s == 3);
          wr(0, ((s << 2) | 3) << (4 * i));
          measure(i, per);
          chk($sformatf("R5 t%0d sel%0d n%0d", i, s, n), per, (n + 1) * ((s == 1) ? 2 : 4));
          ext_run = 0;
        end

    // R7/R8/R9 multi-source status and both clear paths
    wr(0, 0); wr(4, 0); wr(5, 0); wr(6, 0);
    wr(0, 32'h333);
    wr(0, 32'h70EEE);
    rd(0, v); chk("R8 write one keeps", v, 32'h70EEE);
    chk("R7 irq", irq, 1);
    wr(0, 32'h50EEE);
    rd(0, v); chk("R8 write zero clears", v, 32'h50EEE);
    wr(8, 32'hFFFFFFFF);
    rd(0, v); chk("R9 clear reg", v, 32'h40EEE);
    chk("R7 still pending", irq, 1);
    wr(10, 0);
    rd(0, v); chk("R9 clear last", v, 32'h00EEE);
    chk("R7 released", irq, 0);

    // R10 set wins over same-cycle clear
    wr(0, 0); wr(4, 3); wr(0, 3);
    repeat (3) @(negedge clk);
    wr(8, 0);
    rd(0, v); chk("R10 set wins", v[16], 1);
    chk("R10 irq", irq, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule